// File: doc/BRIEF.md
# Tag-Watching Reservation Station

This block is the waiting area in front of one functional unit of an out-of-order core. Each slot holds one operation, its two source operands and the reorder-buffer index that names its result. An operand is present either as a value, supplied at issue by the register file or the reorder buffer, or as the reorder-buffer tag of the instruction that will produce it. While a slot waits it watches the common result bus; when a broadcast tag matches a missing operand, the slot takes the value.

Once both operands of a slot are present, the slot may be sent to the functional unit. At most one slot is sent per cycle, and the lowest-numbered ready slot wins. A sent slot keeps its place until the result bus carries its own destination tag, and then it becomes free. A flush empties every slot at once, for example after a mispredicted branch.

Top module: `rs_station`

## Requirements
- R1: `alloc_ready` is high exactly when at least one slot is empty and `rob_room` is high. An allocation request made while `alloc_ready` is low changes nothing: `free_count` stays the same and nothing is dispatched from it.
- R2: An operand given at allocation with its `_ok` flag high is stored as given, and it appears unchanged on `disp_a` (first operand) or `disp_b` (second operand) when the slot is dispatched.
- R3: A waiting operand whose tag equals `cdb_tag` while `cdb_valid` is high takes `cdb_data` and counts as present from the next cycle.
- R4: If an allocated operand is not ready but the result bus broadcasts its tag in the same cycle as the allocation, the broadcast value is captured at allocation.
- R5: A slot is never dispatched while either of its operands is missing.
- R6: Of the ready slots, the lowest-numbered one is dispatched. At most one dispatch happens per cycle, and `disp_valid` is a register that rises one cycle after the slot is seen ready.
- R7: A dispatch carries the slot's operation code on `disp_op` and its destination reorder-buffer index on `disp_dst`.
- R8: A dispatched slot becomes empty one cycle after the result bus carries a tag equal to its destination index. A slot that has not been dispatched is not freed by such a broadcast.
- R9: When `flush` is high at a clock edge, all slots are empty after that edge, `disp_valid` is low, and any allocation or dispatch in that cycle is dropped.
- R10: After reset, `free_count` equals the number of slots and `disp_valid` is low.
- R11: An allocation fills the lowest-numbered empty slot, and each allocated slot is dispatched at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all slots |
| rob_room | input | 1 | Reorder buffer has a free entry |
| alloc_valid | input | 1 | Allocation request |
| alloc_op | input | OPW | Operation code |
| alloc_dst | input | TAGW | Destination reorder-buffer index |
| alloc_a_ok | input | 1 | First operand value present |
| alloc_a_val | input | DW | First operand value |
| alloc_a_tag | input | TAGW | Producer tag of first operand |
| alloc_b_ok | input | 1 | Second operand value present |
| alloc_b_val | input | DW | Second operand value |
| alloc_b_tag | input | TAGW | Producer tag of second operand |
| cdb_valid | input | 1 | Result bus broadcast valid |
| cdb_tag | input | TAGW | Result bus tag |
| cdb_data | input | DW | Result bus value |
| alloc_ready | output | 1 | An allocation is accepted this cycle |
| free_count | output | $clog2(NSLOT+1) | Number of empty slots |
| disp_valid | output | 1 | Dispatch to the unit |
| disp_op | output | OPW | Dispatched operation |
| disp_a | output | DW | Dispatched first operand |
| disp_b | output | DW | Dispatched second operand |
| disp_dst | output | TAGW | Dispatched destination index |

## Verification
The bench uses the default sizes: four slots, 3-bit tags, 16-bit data and 4-bit operation codes. With only eight tag values, random broadcasts often hit a waiting operand, a sent slot, or both in the same cycle, and two slots can share a destination tag. Four slots fill up within a few cycles, so the full-station refusal and the lowest-index order of allocation and dispatch happen often. Directed cases cover the capture at allocation, a single broadcast that wakes every slot, and a flush.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SL_EMPTY = 2'd0,
    SL_PEND  = 2'd1,
    SL_SENT  = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rs_lowest.sv
module rs_lowest #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
    any = found;
  end

  p_single_grant_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0));
  p_grant_when_req_r6: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (gnt != '0));
endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
#(
  parameter int DW   = 16,
  parameter int TAGW = 3,
  parameter int OPW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            load,
  input  logic [OPW-1:0]  ld_op,
  input  logic [TAGW-1:0] ld_dst,
  input  logic            ld_a_ok,
  input  logic [DW-1:0]   ld_a_val,
  input  logic [TAGW-1:0] ld_a_tag,
  input  logic            ld_b_ok,
  input  logic [DW-1:0]   ld_b_val,
  input  logic [TAGW-1:0] ld_b_tag,
  input  logic            cdb_valid,
  input  logic [TAGW-1:0] cdb_tag,
  input  logic [DW-1:0]   cdb_data,
  input  logic            grant,
  output logic            is_empty,
  output logic            is_ready,
  output logic [OPW-1:0]  op,
  output logic [TAGW-1:0] dst,
  output logic [DW-1:0]   a_val,
  output logic [DW-1:0]   b_val
);
  slot_state_e     st;
  logic            a_ok, b_ok;
  logic [TAGW-1:0] a_tag, b_tag;
  logic            a_hit, b_hit, ld_a_hit, ld_b_hit, own_result;

  assign a_hit      = cdb_valid && (cdb_tag == a_tag) && !a_ok;
  assign b_hit      = cdb_valid && (cdb_tag == b_tag) && !b_ok;
  assign ld_a_hit   = cdb_valid && (cdb_tag == ld_a_tag) && !ld_a_ok;
  assign ld_b_hit   = cdb_valid && (cdb_tag == ld_b_tag) && !ld_b_ok;
  assign own_result = cdb_valid && (cdb_tag == dst);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st <= SL_EMPTY;
    end else if (load) begin
      st    <= SL_PEND;
      op    <= ld_op;
      dst   <= ld_dst;
      a_tag <= ld_a_tag;
      b_tag <= ld_b_tag;
      a_ok  <= ld_a_ok || ld_a_hit;
      b_ok  <= ld_b_ok || ld_b_hit;
      a_val <= ld_a_hit ? cdb_data : ld_a_val;
      b_val <= ld_b_hit ? cdb_data : ld_b_val;
    end else begin
      if (st != SL_EMPTY) begin
        if (a_hit) begin
          a_ok  <= 1'b1;
          a_val <= cdb_data;
        end
        if (b_hit) begin
          b_ok  <= 1'b1;
          b_val <= cdb_data;
        end
      end
      if (st == SL_SENT && own_result) st <= SL_EMPTY;
      else if (grant)                  st <= SL_SENT;
    end
  end

  assign is_empty = (st == SL_EMPTY);
  assign is_ready = (st == SL_PEND) && a_ok && b_ok;

  p_sent_had_ops_r5: assert property (@(posedge clk) disable iff (rst)
    (st == SL_SENT && $past(st) != SL_SENT) |-> $past(a_ok && b_ok));
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (st != SL_EMPTY && a_hit && !flush && !load) |=> (a_ok && a_val == $past(cdb_data)));
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (st == SL_SENT && own_result && !load) |=> (st == SL_EMPTY));
  p_sent_sticks_r11: assert property (@(posedge clk) disable iff (rst)
    (st == SL_SENT && !own_result && !flush) |=> (st == SL_SENT));
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int DW    = 16,
  parameter int TAGW  = 3,
  parameter int OPW   = 4,
  localparam int CW   = $clog2(NSLOT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            rob_room,
  input  logic            alloc_valid,
  input  logic [OPW-1:0]  alloc_op,
  input  logic [TAGW-1:0] alloc_dst,
  input  logic            alloc_a_ok,
  input  logic [DW-1:0]   alloc_a_val,
  input  logic [TAGW-1:0] alloc_a_tag,
  input  logic            alloc_b_ok,
  input  logic [DW-1:0]   alloc_b_val,
  input  logic [TAGW-1:0] alloc_b_tag,
  input  logic            cdb_valid,
  input  logic [TAGW-1:0] cdb_tag,
  input  logic [DW-1:0]   cdb_data,
  output logic            alloc_ready,
  output logic [CW-1:0]   free_count,
  output logic            disp_valid,
  output logic [OPW-1:0]  disp_op,
  output logic [DW-1:0]   disp_a,
  output logic [DW-1:0]   disp_b,
  output logic [TAGW-1:0] disp_dst
);
  logic [NSLOT-1:0] empty_v, ready_v, free_sel, pick, load_v, grant_v;
  logic             any_free, any_ready, alloc_fire;
  logic [OPW-1:0]   s_op  [NSLOT];
  logic [TAGW-1:0]  s_dst [NSLOT];
  logic [DW-1:0]    s_a   [NSLOT];
  logic [DW-1:0]    s_b   [NSLOT];

  rs_lowest #(.N(NSLOT)) u_free_pick (
    .clk(clk), .rst(rst), .req(empty_v), .gnt(free_sel), .any(any_free)
  );
  rs_lowest #(.N(NSLOT)) u_ready_pick (
    .clk(clk), .rst(rst), .req(ready_v), .gnt(pick), .any(any_ready)
  );

  assign alloc_ready = any_free && rob_room;
  assign alloc_fire  = alloc_valid && alloc_ready && !flush;
  assign load_v      = alloc_fire ? free_sel : '0;
  assign grant_v     = flush ? '0 : pick;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    rs_slot #(.DW(DW), .TAGW(TAGW), .OPW(OPW)) u_slot (
      .clk(clk), .rst(rst), .flush(flush), .load(load_v[g]),
      .ld_op(alloc_op), .ld_dst(alloc_dst),
      .ld_a_ok(alloc_a_ok), .ld_a_val(alloc_a_val), .ld_a_tag(alloc_a_tag),
      .ld_b_ok(alloc_b_ok), .ld_b_val(alloc_b_val), .ld_b_tag(alloc_b_tag),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .grant(grant_v[g]),
      .is_empty(empty_v[g]), .is_ready(ready_v[g]),
      .op(s_op[g]), .dst(s_dst[g]), .a_val(s_a[g]), .b_val(s_b[g])
    );
  end

  always_comb begin
    free_count = '0;
    for (int i = 0; i < NSLOT; i++) free_count = free_count + CW'(empty_v[i]);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      disp_valid <= 1'b0;
    end else begin
      disp_valid <= any_ready;
    end
    for (int i = 0; i < NSLOT; i++) begin
      if (pick[i]) begin
        disp_op  <= s_op[i];
        disp_dst <= s_dst[i];
        disp_a   <= s_a[i];
        disp_b   <= s_b[i];
      end
    end
  end

  p_full_blocks_r1: assert property (@(posedge clk) disable iff (rst)
    (free_count == '0) |-> !alloc_ready);
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (free_count == CW'(NSLOT)) && !disp_valid);
  p_alloc_takes_slot_r11: assert property (@(posedge clk) disable iff (rst)
    (alloc_fire && !cdb_valid) |=> (free_count == $past(free_count) - CW'(1)));
endmodule

// File: tb/rs_station_tb_top.sv
module rs_station_tb_top;
  localparam int NSLOT = 4, DW = 16, TAGW = 3, OPW = 4;
  localparam int CW = $clog2(NSLOT + 1);

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0, rob_room = 1'b1, alloc_valid = 1'b0;
  logic [OPW-1:0]  alloc_op = '0;
  logic [TAGW-1:0] alloc_dst = '0, alloc_a_tag = '0, alloc_b_tag = '0, cdb_tag = '0;
  logic            alloc_a_ok = 1'b0, alloc_b_ok = 1'b0, cdb_valid = 1'b0;
  logic [DW-1:0]   alloc_a_val = '0, alloc_b_val = '0, cdb_data = '0;
  logic            alloc_ready, disp_valid;
  logic [CW-1:0]   free_count;
  logic [OPW-1:0]  disp_op;
  logic [DW-1:0]   disp_a, disp_b;
  logic [TAGW-1:0] disp_dst;

  int n_checks = 0, n_errors = 0;

  always #2 clk = ~clk;

  rs_station #(.NSLOT(NSLOT), .DW(DW), .TAGW(TAGW), .OPW(OPW)) dut_i (
    .clk(clk), .rst(rst), .flush(flush), .rob_room(rob_room),
    .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_dst(alloc_dst),
    .alloc_a_ok(alloc_a_ok), .alloc_a_val(alloc_a_val), .alloc_a_tag(alloc_a_tag),
    .alloc_b_ok(alloc_b_ok), .alloc_b_val(alloc_b_val), .alloc_b_tag(alloc_b_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .alloc_ready(alloc_ready), .free_count(free_count), .disp_valid(disp_valid),
    .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b), .disp_dst(disp_dst)
  );

  // reference model: 0 empty, 1 waiting, 2 sent
  int              m_st [NSLOT];
  logic [OPW-1:0]  m_op [NSLOT];
  logic [TAGW-1:0] m_dst [NSLOT], m_at [NSLOT], m_bt [NSLOT];
  logic            m_aok [NSLOT], m_bok [NSLOT];
  logic [DW-1:0]   m_av [NSLOT], m_bv [NSLOT];
  logic            e_dv = 1'b0;
  logic [OPW-1:0]  e_op = '0;
  logic [DW-1:0]   e_a = '0, e_b = '0;
  logic [TAGW-1:0] e_dst = '0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_free();
    int c = 0;
    for (int i = 0; i < NSLOT; i++) if (m_st[i] == 0) c++;
    return c;
  endfunction

  function automatic int lowest_free();
    for (int i = 0; i < NSLOT; i++) if (m_st[i] == 0) return i;
    return -1;
  endfunction

  function automatic int lowest_ready();
    for (int i = 0; i < NSLOT; i++) if (m_st[i] == 1 && m_aok[i] && m_bok[i]) return i;
    return -1;
  endfunction

  // one clock step with the inputs already driven; req labels the checks
  task automatic step(input string req);
    int  pk, fr;
    logic rdy;
    #1;
    rdy = (exp_free() > 0) && rob_room;
    check("R1", "alloc_ready", alloc_ready, rdy);
    check(req, "free_count", free_count, exp_free());
    pk = lowest_ready();
    fr = lowest_free();
    if (flush) begin
      e_dv = 1'b0;
      for (int i = 0; i < NSLOT; i++) m_st[i] = 0;
    end else begin
      e_dv = (pk >= 0);
      if (pk >= 0) begin
        e_op = m_op[pk]; e_a = m_av[pk]; e_b = m_bv[pk]; e_dst = m_dst[pk];
      end
      for (int i = 0; i < NSLOT; i++) begin
        if (m_st[i] != 0 && cdb_valid) begin
          if (!m_aok[i] && m_at[i] == cdb_tag) begin m_aok[i] = 1'b1; m_av[i] = cdb_data; end
          if (!m_bok[i] && m_bt[i] == cdb_tag) begin m_bok[i] = 1'b1; m_bv[i] = cdb_data; end
        end
        if (m_st[i] == 2 && cdb_valid && m_dst[i] == cdb_tag) m_st[i] = 0;
        else if (i == pk) m_st[i] = 2;
      end
      if (alloc_valid && rdy) begin
        m_st[fr] = 1; m_op[fr] = alloc_op; m_dst[fr] = alloc_dst;
        m_at[fr] = alloc_a_tag; m_bt[fr] = alloc_b_tag;
        m_aok[fr] = alloc_a_ok || (cdb_valid && cdb_tag == alloc_a_tag);
        m_bok[fr] = alloc_b_ok || (cdb_valid && cdb_tag == alloc_b_tag);
        m_av[fr] = (!alloc_a_ok && cdb_valid && cdb_tag == alloc_a_tag) ? cdb_data : alloc_a_val;
        m_bv[fr] = (!alloc_b_ok && cdb_valid && cdb_tag == alloc_b_tag) ? cdb_data : alloc_b_val;
      end
    end
    @(negedge clk);
    check(req, "disp_valid", disp_valid, e_dv);
    if (e_dv) begin
      check(req, "disp_op (R7)", disp_op, e_op);
      check(req, "disp_dst (R7)", disp_dst, e_dst);
      check(req, "disp_a", disp_a, e_a);
      check(req, "disp_b", disp_b, e_b);
    end
  endtask

  task automatic idle();
    alloc_valid = 1'b0; cdb_valid = 1'b0; flush = 1'b0; rob_room = 1'b1;
  endtask

  task automatic alloc(input logic [OPW-1:0] op, input logic [TAGW-1:0] d,
                       input logic aok, input logic [DW-1:0] av, input logic [TAGW-1:0] at,
                       input logic bok, input logic [DW-1:0] bv, input logic [TAGW-1:0] bt);
    alloc_valid = 1'b1; alloc_op = op; alloc_dst = d;
    alloc_a_ok = aok; alloc_a_val = av; alloc_a_tag = at;
    alloc_b_ok = bok; alloc_b_val = bv; alloc_b_tag = bt;
  endtask

  task automatic bcast(input logic [TAGW-1:0] t, input logic [DW-1:0] v);
    cdb_valid = 1'b1; cdb_tag = t; cdb_data = v;
  endtask

  initial begin
    #400000;
    n_errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSLOT; i++) m_st[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10", "free_count", free_count, NSLOT);
    check("R10", "disp_valid", disp_valid, 0);
    rob_room = 1'b0; #1;
    check("R1", "alloc_ready without rob room", alloc_ready, 0);
    @(negedge clk); idle();

    // R2/R7: both operands present
    alloc(4'h3, 3'd6, 1'b1, 16'h1234, 3'd0, 1'b1, 16'hBEEF, 3'd0);
    step("R2"); idle();
    step("R2"); // dispatch appears here
    check("R2", "direct disp_a", disp_a, 16'h1234);
    check("R7", "direct disp_dst", disp_dst, 3'd6);
    bcast(3'd6, 16'h0); step("R8"); idle();
    step("R8");
    check("R8", "slot freed", free_count, NSLOT);

    // R3/R5: waiting operand, then wakeup
    alloc(4'h5, 3'd1, 1'b0, 16'h0, 3'd5, 1'b1, 16'h0042, 3'd0);
    step("R5"); idle();
    step("R5"); step("R5");
    check("R5", "no dispatch while waiting", disp_valid, 0);
    bcast(3'd5, 16'hA5A5); step("R3"); idle();
    step("R3");
    check("R3", "captured value", disp_a, 16'hA5A5);
    bcast(3'd1, 16'h0); step("R8"); idle();

    // R4: broadcast in the allocation cycle
    alloc(4'h2, 3'd2, 1'b0, 16'h0, 3'd7, 1'b0, 16'h0, 3'd7);
    bcast(3'd7, 16'h7777); step("R4"); idle();
    step("R4");
    check("R4", "captured at allocation", disp_b, 16'h7777);
    bcast(3'd2, 16'h0); step("R8"); idle(); step("R8");

    // R1/R6/R11: fill all four waiting on tag 4, then refuse, then wake together
    for (int k = 0; k < NSLOT; k++) begin
      alloc(4'(k), 3'(k), 1'b0, 16'h0, 3'd4, 1'b1, 16'(k), 3'd0);
      step("R11");
    end
    alloc(4'hF, 3'd3, 1'b1, 16'h1, 3'd0, 1'b1, 16'h1, 3'd0);
    step("R1"); idle(); step("R1");
    check("R1", "full station keeps count", free_count, 0);
    bcast(3'd4, 16'h4444); step("R6"); idle();
    for (int k = 0; k < NSLOT; k++) begin
      step("R6");
      check("R6", "order by slot index", disp_op, k);
    end
    step("R11");
    check("R11", "no second dispatch", disp_valid, 0);

    // R9: flush
    flush = 1'b1; step("R9"); idle();
    check("R9", "empty after flush", free_count, NSLOT);
    alloc(4'h1, 3'd0, 1'b1, 16'h9, 3'd0, 1'b1, 16'h9, 3'd0);
    flush = 1'b1; step("R9"); idle();
    step("R9");
    check("R9", "flushed allocation dropped", disp_valid, 0);

    // random phase
    void'($urandom(32'd7));
    for (int n = 0; n < 4000; n++) begin
      rob_room    = ($urandom % 5) != 0;
      alloc_valid = ($urandom % 5) < 3;
      alloc_op    = OPW'($urandom); alloc_dst = TAGW'($urandom);
      alloc_a_ok  = $urandom % 2; alloc_a_val = DW'($urandom); alloc_a_tag = TAGW'($urandom);
      alloc_b_ok  = $urandom % 2; alloc_b_val = DW'($urandom); alloc_b_tag = TAGW'($urandom);
      cdb_valid   = ($urandom % 5) < 3; cdb_tag = TAGW'($urandom); cdb_data = DW'($urandom);
      flush       = ($urandom % 200) == 0;
      step("R3");
    end
    idle();
    step("R9");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule